// File: doc/BRIEF.md
# Command-Driven SPI Frame Engine

This block runs one complete SPI frame (mode 0: clock idles low, data launched while the clock is low, sampled on the rising edge) from a single 32-bit command word. The command names the target chip select, the number of characters in the frame, how many leading characters have their received data thrown away, and whether reception is suppressed altogether. Each chip select also has its own mode word, which sets the character width, the bit order, the chip-select polarity and three kinds of idle gap: setup before the first clock, hold after the last clock, and spacing between characters.

Transmit characters are pulled from an external FIFO through a valid/pop handshake. Received characters are offered to an external FIFO as one-cycle push pulses. All timing is paced by a `tick` strobe that marks each half period of the serial clock, so the divider stays outside the block. The engine is meant for write-then-read flash-style accesses: command and address characters go out first, their received echoes are skipped, and only the response characters reach the receive FIFO.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `sck`, `tx_pop` and `rx_push` are low, and every chip-select line sits at its inactive level.
- R2: A command is accepted only while idle, on a cycle with `cmd_valid` high. Command bits 31:30 pick the chip-select line. Only that line goes active, for the whole frame. A `cmd_valid` pulse during a frame is ignored.
- R3: Command bits 15:0 hold the character count minus one. Exactly that many characters plus one are popped from the transmit FIFO and shifted. Each character takes mode-word bits 19:16 plus one clock periods (4 to 16 bits). MOSI changes only while SCK is low, and MISO is sampled on each rising edge.
- R4: When mode-word bit 29 is set, each character goes out most significant bit first (bit LEN first). When it is clear, bit 0 goes first. Received bits are placed back in the same order, so data looped back from MOSI returns unchanged.
- R5: Command bits 23:16 give a skip count. The received data of the first that many characters is discarded. Every later character is pushed to the receive FIFO, in order, with the unused upper bits zero.
- R6: When command bit 27 is set, the frame is transmit-only and `rx_push` never pulses.
- R7: When mode-word bit 20 is set, that line's chip select is active low. When it is clear, the line is active high. Lines that are not selected always rest at their inactive level.
- R8: Mode-word bits 15:12 (BEF) set the setup gap. Between the chip select going active and the first rising SCK edge there are 2*BEF+1 to 2*BEF+2 ticks.
- R9: Mode-word bits 11:8 (AFT) set the hold gap. Between the last falling SCK edge and the chip select being released there are 2*AFT to 2*AFT+1 ticks.
- R10: Mode-word bits 7:3 (CG) set the spacing between characters. When CG is nonzero, the low time from a character's last falling edge to the next character's first rising edge is 2*CG+1 to 2*CG+2 ticks. Inside a character each low phase is one tick.
- R11: When the transmit FIFO is empty at a character boundary, SCK stays low and the frame waits. It resumes with no lost or repeated data once a character arrives.
- R12: `done` pulses for one cycle per command, in the cycle the chip select is released and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-SCK-period strobe |
| cmd_valid | input | 1 | Start request |
| cmd | input | 32 | Command word |
| csmode | input | NCS*32 | Mode word per chip select, line i in bits 32i+31:32i |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 16 | Head of transmit FIFO |
| tx_pop | output | 1 | Take the head of the transmit FIFO |
| rx_push | output | 1 | Received character valid |
| rx_data | output | 16 | Received character |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | NCS | Chip-select lines, polarity per mode word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |

## Verification
The hardest case to reach from the ports is the underrun stall. The frame must run dry exactly at a character boundary, while the chip select is still held, and then resume. The bench gets there by loading only part of a frame's characters before issuing the command. It waits until the queue has drained and the clock has sat low for many cycles, then supplies the remainder. The received data must still match. A second start request is also fired into that stalled frame, so the ignore rule is tested in the same run.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int NCS = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd,
  input  logic [NCS*32-1:0] csmode,
  input  logic              tx_valid,
  input  logic [CW-1:0]     tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [CW-1:0]     rx_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NCS-1:0]    cs_o,
  output logic              busy,
  output logic              done
);
  localparam int SW = (NCS > 2) ? 2 : 1;
  localparam int BW = $clog2(CW);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LOAD, S_SHIFT, S_GAP, S_POST} st_t;

  st_t           st;
  logic [SW-1:0] sel;
  logic          rev, txonly;
  logic [BW-1:0] len, bidx, pos;
  logic [3:0]    aft;
  logic [4:0]    cg;
  logic [7:0]    skip;
  logic [15:0]   left;
  logic [5:0]    gcnt;
  logic [CW-1:0] txsh, rxsh;
  logic [SW-1:0] cmd_sel;
  logic [31:0]   mw;
  logic [NCS-1:0] pol, act;
  logic          unused_bits;

  assign cmd_sel = cmd[30 +: SW];
  assign mw      = csmode[int'(cmd_sel)*32 +: 32];
  assign pos     = rev ? (len - bidx) : bidx;
  assign busy    = (st != S_IDLE);
  assign tx_pop  = (st == S_LOAD) && tx_valid;
  assign mosi    = (st == S_SHIFT) && txsh[pos];
  assign rx_data = rxsh;
  assign unused_bits = ^{cmd[29:28], cmd[26:24], csmode};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign pol[i]  = csmode[i*32+20];
    assign act[i]  = busy && (int'(sel) == i);
    assign cs_o[i] = act[i] ^ pol[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; rev <= 1'b0; txonly <= 1'b0;
      len <= '0; aft <= '0; cg <= '0; skip <= '0; left <= '0;
      gcnt <= '0; txsh <= '0; rxsh <= '0; bidx <= '0;
      sck <= 1'b0; rx_push <= 1'b0; done <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          sel    <= cmd_sel;
          rev    <= mw[29];
          len    <= BW'(mw[19:16]);
          aft    <= mw[11:8];
          cg     <= mw[7:3];
          txonly <= cmd[27];
          skip   <= cmd[23:16];
          left   <= cmd[15:0];
          gcnt   <= {1'b0, mw[15:12], 1'b0};
          st     <= S_PRE;
        end
        S_PRE, S_GAP, S_POST: begin
          if (gcnt == 6'd0) begin
            if (st == S_POST) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_LOAD;
            end
          end else if (tick) begin
            gcnt <= gcnt - 6'd1;
          end
        end
        S_LOAD: if (tx_valid) begin
          txsh <= tx_data;
          rxsh <= '0;
          bidx <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sck) begin
            sck       <= 1'b1;
            rxsh[pos] <= miso;
          end else begin
            sck <= 1'b0;
            if (bidx == len) begin
              if (skip != 8'd0) skip <= skip - 8'd1;
              else if (!txonly) rx_push <= 1'b1;
              if (left == 16'd0) begin
                st   <= S_POST;
                gcnt <= {1'b0, aft, 1'b0};
              end else begin
                left <= left - 16'd1;
                if (cg != 5'd0) begin
                  st   <= S_GAP;
                  gcnt <= {cg, 1'b0};
                end else begin
                  st <= S_LOAD;
                end
              end
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_o == pol) && !sck);
  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_o ^ pol) <= 1);
  a_r2_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_o));
  a_r3_push_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !sck && $past(sck));
  a_r6_txonly_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txonly) |-> !rx_push);
  a_r11_stall_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !tx_valid) |=> !sck && $stable(mosi));
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int NCS = 4;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, cmd_valid = 1'b0, tx_valid = 1'b0;
  logic [31:0] cmd = '0;
  logic [NCS*32-1:0] csmode = '0;
  logic [15:0] tx_data = '0;
  logic tx_pop, rx_push, sck, mosi, busy, done;
  logic [15:0] rx_data;
  logic [NCS-1:0] cs_o;

  spi_cmd_engine #(.NCS(NCS), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd(cmd),
    .csmode(csmode), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .miso(mosi), .sck(sck), .mosi(mosi),
    .cs_o(cs_o), .busy(busy), .done(done));

  int n_chk = 0, n_fail = 0;
  logic [15:0] txq[$], expq[$], sentq[$];
  int T = 0, tdiv = 0;
  int n_rise = 0, n_push = 0, n_done = 0;
  int t_cs_on, t_cs_off, t_first, t_fall, gap_bad, n_gap, ord_bad, cs_bad, done_busy;
  int f_rev, f_clen, f_csel, f_cg, bitk;
  logic sck_p = 1'b0, busy_p = 1'b0;
  bit finished = 0;
  logic [31:0] seed = 32'h1ace_b00c;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (tx_pop && txq.size() > 0) void'(txq.pop_front());

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_push) begin
        n_push++;
        if (expq.size() == 0) chk(0, "R5", "unexpected rx push", rx_data, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(rx_data == e, "R5", "rx word (R4 order)", rx_data, e);
        end
      end
      if (done) begin
        n_done++;
        if (busy) done_busy++;
      end
      if (busy && !busy_p) t_cs_on = T;
      if (!busy && busy_p) t_cs_off = T;
      if (busy) for (int i = 0; i < NCS; i++)
        if (cs_o[i] !== ((i == f_csel) ^ csmode[i*32+20])) cs_bad++;
      if (sck && !sck_p) begin
        n_rise++;
        if (t_first < 0) t_first = T;
        else if (T - t_fall != 1) begin
          n_gap++;
          if (T - t_fall < 2*f_cg+1 || T - t_fall > 2*f_cg+2) gap_bad++;
        end
        if (sentq.size() > 0) begin
          logic [15:0] c;
          logic eb;
          c = sentq[0];
          eb = f_rev ? c[f_clen-1-bitk] : c[bitk];
          if (mosi !== eb) ord_bad++;
          bitk++;
          if (bitk == f_clen) begin bitk = 0; void'(sentq.pop_front()); end
        end
      end
      if (!sck && sck_p) t_fall = T;
      sck_p = sck;
      busy_p = busy;
    end
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
    if (tdiv == 0) T++;
    tx_valid <= (txq.size() > 0);
    tx_data  <= (txq.size() > 0) ? txq[0] : 16'h0;
  end

  task automatic frame(input int csel, input int nch, input int skip, input bit txo,
                       input bit rev, input bit pol, input int clen, input int bef,
                       input int aft, input int cg, input int stall_at);
    logic [31:0] mw;
    logic [15:0] held[$];
    int r0, p0, d0, exp_push;
    mw = (32'(rev) << 29) | (32'(pol) << 20) | (32'(clen-1) << 16) |
         (32'(bef) << 12) | (32'(aft) << 8) | (32'(cg) << 3);
    @(negedge clk);
    csmode[csel*32 +: 32] = mw;
    f_rev = rev; f_clen = clen; f_csel = csel; f_cg = cg; bitk = 0;
    t_first = -1; gap_bad = 0; n_gap = 0; ord_bad = 0; cs_bad = 0; done_busy = 0;
    r0 = n_rise; p0 = n_push; d0 = n_done;
    exp_push = txo ? 0 : ((nch > skip) ? nch - skip : 0);
    for (int i = 0; i < nch; i++) begin
      logic [15:0] c;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      c = seed[15:0] & 16'((1 << clen) - 1);
      if (stall_at == 0 || i < stall_at) txq.push_back(c); else held.push_back(c);
      sentq.push_back(c);
      if (!txo && i >= skip) expq.push_back(c);
    end
    cmd <= (32'(csel) << 30) | (32'(txo) << 27) | (32'(skip) << 16) | 32'(nch - 1);
    cmd_valid <= 1'b1;
    @(negedge clk);
    cmd_valid <= 1'b0;
    if (stall_at != 0) begin
      int rs;
      while (txq.size() != 0) @(negedge clk);
      repeat (300) @(negedge clk);
      rs = n_rise;
      cmd <= 32'h0000_0000;
      cmd_valid <= 1'b1;
      @(negedge clk);
      cmd_valid <= 1'b0;
      repeat (100) @(negedge clk);
      chk(n_rise == rs && sck == 1'b0 && busy, "R11", "sck idle while tx empty", n_rise - rs, 0);
      while (held.size() > 0) txq.push_back(held.pop_front());
    end
    while (n_done == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_rise - r0 == nch*clen, "R3", "rising edges in frame", n_rise - r0, nch*clen);
    chk(txq.size() == 0, "R3", "tx fifo drained", txq.size(), 0);
    chk(ord_bad == 0, "R4", "mosi bit order mismatches", ord_bad, 0);
    chk(n_push - p0 == exp_push, "R5", "rx pushes", n_push - p0, exp_push);
    if (txo) chk(n_push == p0, "R6", "tx-only pushes", n_push - p0, 0);
    chk(cs_bad == 0, "R2", "cs line mismatches (R7 polarity)", cs_bad, 0);
    chk(t_first - t_cs_on >= 2*bef+1 && t_first - t_cs_on <= 2*bef+2, "R8",
        "setup ticks", t_first - t_cs_on, 2*bef+1);
    chk(t_cs_off - t_fall >= 2*aft && t_cs_off - t_fall <= 2*aft+1, "R9",
        "hold ticks", t_cs_off - t_fall, 2*aft);
    if (cg > 0 && stall_at == 0)
      chk(gap_bad == 0 && n_gap == nch-1, "R10", "char gaps in range", n_gap, nch-1);
    chk(n_done - d0 == 1 && done_busy == 0, "R12", "done pulses", n_done - d0, 1);
    chk(expq.size() == 0 && sentq.size() == 0, "R5", "scoreboard empty", expq.size(), 0);
  endtask

  initial begin
    csmode[20] = 1'b0; csmode[52] = 1'b1; csmode[84] = 1'b1; csmode[116] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_o == 4'b0110, "R1", "cs idle levels (R7)", cs_o, 4'b0110);
    chk(!busy && !done && !sck, "R1", "idle outputs", {busy, done, sck}, 0);
    chk(!tx_pop && !rx_push, "R1", "no fifo traffic", {tx_pop, rx_push}, 0);
    frame(0, 4, 0, 0, 1, 0, 8, 1, 1, 0, 0);
    frame(1, 5, 2, 0, 0, 1, 16, 3, 2, 2, 0);
    frame(2, 3, 0, 1, 1, 1, 4, 0, 0, 1, 0);
    frame(3, 4, 1, 0, 0, 0, 12, 2, 0, 0, 2);
    frame(0, 2, 2, 0, 1, 1, 5, 1, 3, 3, 0);
    frame(1, 6, 0, 0, 0, 0, 9, 0, 1, 4, 0);
    chk(cs_o == {csmode[116], csmode[84], csmode[52], csmode[20]}, "R7",
        "cs idle after frames", cs_o, {csmode[116], csmode[84], csmode[52], csmode[20]});
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule